// File: doc/BRIEF.md
# Emulated EEPROM Version-Slot Controller

This controller makes a memory that can only be erased a whole block at a time behave like memory with writable words. Each logical word has a fixed group of version slots inside its block. A write never changes a slot that is already used: it puts the new value into the next free slot of that word. A read returns the newest version. When a write finds that every slot of its word is used, the controller compacts the whole block. It copies the newest value of every word in the block into a frame of a copy buffer, erases the block, and writes each saved value back into the first slot of its word. The value being written takes the place of the old value of the target word.

The copy buffer holds a fixed number of frames. A frame is used up each time a block is compacted. When all frames are used, the status output `ereq_o` goes high. The next compaction must then erase the copy buffer first, which makes that write the slowest of the three latency classes: plain append, compaction, and compaction with buffer erase. Software can pulse `start_i` while the controller is idle to erase the buffer ahead of time. Every operation, including a read and a manual erase, ends with a one-cycle `irq_o` pulse and leaves `done_o` high. Both arrays are register arrays, and the program, erase and per-word copy times are cycle-count parameters.

The state machine has these states and transitions:
- IDLE to PROG on a write to a word that has a free slot.
- IDLE to COPY on a write to a full word while the buffer has room.
- IDLE to CB_ERASE on a write to a full word while the buffer is full, or on `start_i`.
- IDLE to FINISH on a read.
- PROG to FINISH.
- CB_ERASE to COPY during a compaction, or to FINISH after a manual erase.
- COPY to BLK_ERASE after the last word is copied.
- BLK_ERASE to RESTORE.
- RESTORE to FINISH after the last word is restored.
- FINISH to IDLE.

Top module: `vslot_eeprom`

## Requirements
- R1: After reset `busy_o`, `done_o` and `ereq_o` are 0, and every word reads as all ones, the erased value.
- R2: A read returns the most recently written value of the addressed word. The word address is block × WORDS_PER_BLOCK + word-in-block.
- R3: A write to a word with a free slot is a plain append: `busy_o` stays high for at most PROG_CYC+2 cycles.
- R4: From the erased state a word takes SLOTS plain writes. The next write to it starts a compaction, whose busy time is at least ERASE_CYC and less than twice ERASE_CYC.
- R5: After a compaction every word of that block reads its newest value from before the compaction, and the target word reads the value just written.
- R6: After a compaction every word of the compacted block takes SLOTS−1 plain writes, and the next write to the target word compacts again.
- R7: A compaction of one block changes neither the values nor the slot usage of words in the other block.
- R8: `ereq_o` rises once CB_FRAMES compactions have used the buffer. It changes only while busy. A compaction started while it is high takes at least twice ERASE_CYC, and afterwards `ereq_o` reads 0.
- R9: A `start_i` pulse while idle erases the copy buffer. The operation completes with `irq_o`, `ereq_o` then reads 0, and the next compaction falls in the R4 latency class.
- R10: While `busy_o` is high, write, read and start requests are ignored. Priority when idle is write, then read, then start.
- R11: Each operation raises `irq_o` for exactly one cycle at its end. `done_o` is 0 while busy and 1 after completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_req_i | input | 1 | Write request, sampled while idle |
| rd_req_i | input | 1 | Read request, sampled while idle |
| start_i | input | 1 | Manual copy-buffer erase request |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read result, valid from completion |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Last operation completed |
| irq_o | output | 1 | One-cycle completion pulse |
| ereq_o | output | 1 | Copy buffer full, erase needed |

## Verification
The bench builds the controller with:

| Parameter | Value |
|---|---|
| WORDS_PER_BLOCK | 4 |
| BLOCKS | 2 |
| DATA_W | 16 |
| SLOTS | 7 |
| CB_FRAMES | 2 |
| PROG_CYC | 3 |
| COPY_CYC | 2 |
| ERASE_CYC | 20 |

With these values the three latency classes take about 4, 37 and 57 busy cycles, so a window of busy cycles tells them apart. The small block and buffer bring within a few hundred cycles a full run of the slot set and two compactions that fill the buffer. They also bring the forced buffer erase in the other block and a manual erase followed by a fast compaction.

// File: rtl/vslot_pkg.sv
package vslot_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG,
        ST_CB_ERASE,
        ST_COPY,
        ST_BLK_ERASE,
        ST_RESTORE,
        ST_FINISH
    } vslot_state_e;
endpackage

// File: rtl/vslot_timer.sv
module vslot_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] len,
    output logic          expired
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= len;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == TW'(1));
endmodule

// File: rtl/vslot_main.sv
module vslot_main #(
    parameter int DW    = 32,
    parameter int NW    = 16,
    parameter int WPB   = 8,
    parameter int SLOTS = 7,
    parameter int AW    = $clog2(NW),
    parameter int BW    = $clog2(NW / WPB)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          app_en,
    input  logic          rst_en,
    input  logic          ers_en,
    input  logic [AW-1:0] w_idx,
    input  logic [DW-1:0] w_data,
    input  logic [BW-1:0] ers_blk,
    input  logic [AW-1:0] ra_idx,
    output logic [DW-1:0] ra_data,
    output logic          ra_full,
    input  logic [AW-1:0] rb_idx,
    output logic [DW-1:0] rb_data
);
    localparam int CW = $clog2(SLOTS + 1);
    localparam int SW = $clog2(SLOTS);

    logic [DW-1:0] mem [NW][SLOTS];
    logic [CW-1:0] used [NW];

    for (genvar w = 0; w < NW; w++) begin : g_word
        localparam int unsigned MYB = w / WPB;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                used[w] <= '0;
                for (int s = 0; s < SLOTS; s++) mem[w][s] <= '1;
            end else if (ers_en && ers_blk == MYB[BW-1:0]) begin
                used[w] <= '0;
                for (int s = 0; s < SLOTS; s++) mem[w][s] <= '1;
            end else if (w_idx == AW'(w)) begin
                if (app_en) begin
                    mem[w][used[w][SW-1:0]] <= w_data;
                    used[w]                 <= used[w] + 1'b1;
                end else if (rst_en) begin
                    mem[w][0] <= w_data;
                    used[w]   <= CW'(1);
                end
            end
        end
    end

    always_comb begin
        ra_full = (used[ra_idx] == CW'(SLOTS));
        if (used[ra_idx] == '0) ra_data = '1;
        else                    ra_data = mem[ra_idx][SW'(used[ra_idx] - 1'b1)];
        if (used[rb_idx] == '0) rb_data = '1;
        else                    rb_data = mem[rb_idx][SW'(used[rb_idx] - 1'b1)];
    end
endmodule

// File: rtl/vslot_cbuf.sv
module vslot_cbuf #(
    parameter int DW     = 32,
    parameter int WPB    = 8,
    parameter int FRAMES = 2,
    parameter int IW     = $clog2(WPB)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          commit,
    input  logic          erase,
    input  logic [IW-1:0] idx,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    output logic          full
);
    localparam int FW = $clog2(FRAMES + 1);
    localparam int XW = $clog2(FRAMES);

    logic [DW-1:0] mem [FRAMES][WPB];
    logic [FW-1:0] fill;

    assign full = (fill == FW'(FRAMES));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n || erase) begin
            fill <= '0;
            for (int f = 0; f < FRAMES; f++)
                for (int i = 0; i < WPB; i++) mem[f][i] <= '1;
        end else begin
            if (wr_en && !full) mem[XW'(fill)][idx] <= wr_data;
            if (commit && !full) fill <= fill + 1'b1;
        end
    end

    always_comb begin
        if (fill == '0) rd_data = '1;
        else            rd_data = mem[XW'(fill - 1'b1)][idx];
    end
endmodule

// File: rtl/vslot_eeprom.sv
module vslot_eeprom #(
    parameter int DATA_W          = 32,
    parameter int WORDS_PER_BLOCK = 8,
    parameter int BLOCKS          = 2,
    parameter int SLOTS           = 7,
    parameter int CB_FRAMES       = 2,
    parameter int PROG_CYC        = 16,
    parameter int COPY_CYC        = 4,
    parameter int ERASE_CYC       = 4000,
    parameter int ADDR_W          = $clog2(WORDS_PER_BLOCK * BLOCKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req_i,
    input  logic              rd_req_i,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              irq_o,
    output logic              ereq_o
);
    import vslot_pkg::*;

    localparam int NW = WORDS_PER_BLOCK * BLOCKS;
    localparam int IW = $clog2(WORDS_PER_BLOCK);
    localparam int BW = ADDR_W - IW;
    localparam int TW = $clog2(PROG_CYC + COPY_CYC + ERASE_CYC + 1);

    vslot_state_e state, state_n;

    logic [ADDR_W-1:0] tgt;
    logic [DATA_W-1:0] tdata;
    logic [IW-1:0]     widx;
    logic              manual;
    logic              done_q;
    logic [DATA_W-1:0] rdata_q;

    logic              tm_load, tm_exp;
    logic [TW-1:0]     tm_len;
    logic              last_w, step;
    logic              m_app, m_rst, m_ers;
    logic [ADDR_W-1:0] m_widx, rb_idx;
    logic [DATA_W-1:0] m_wdata, ra_data, rb_data, cb_rd;
    logic              ra_full;
    logic              cb_wr, cb_commit, cb_ers, cb_full;

    assign last_w = (widx == IW'(WORDS_PER_BLOCK - 1));
    assign rb_idx = {tgt[ADDR_W-1:IW], widx};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // next state
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: begin
                if (wr_req_i) begin
                    if (!ra_full)     state_n = ST_PROG;
                    else if (cb_full) state_n = ST_CB_ERASE;
                    else              state_n = ST_COPY;
                end else if (rd_req_i) begin
                    state_n = ST_FINISH;
                end else if (start_i) begin
                    state_n = ST_CB_ERASE;
                end
            end
            ST_PROG:      if (tm_exp) state_n = ST_FINISH;
            ST_CB_ERASE:  if (tm_exp) state_n = manual ? ST_FINISH : ST_COPY;
            ST_COPY:      if (tm_exp && last_w) state_n = ST_BLK_ERASE;
            ST_BLK_ERASE: if (tm_exp) state_n = ST_RESTORE;
            ST_RESTORE:   if (tm_exp && last_w) state_n = ST_FINISH;
            ST_FINISH:    state_n = ST_IDLE;
            default:      state_n = ST_IDLE;
        endcase
    end

    // outputs and control strobes
    always_comb begin
        m_app     = 1'b0;
        m_rst     = 1'b0;
        m_ers     = 1'b0;
        cb_wr     = 1'b0;
        cb_commit = 1'b0;
        cb_ers    = 1'b0;
        m_widx    = tgt;
        m_wdata   = tdata;
        step      = 1'b0;
        unique case (state)
            ST_PROG:      m_app = tm_exp;
            ST_CB_ERASE:  cb_ers = tm_exp;
            ST_COPY: begin
                cb_wr     = tm_exp;
                cb_commit = tm_exp && last_w;
                step      = tm_exp && !last_w;
            end
            ST_BLK_ERASE: m_ers = tm_exp;
            ST_RESTORE: begin
                m_rst   = tm_exp;
                step    = tm_exp && !last_w;
                m_widx  = rb_idx;
                m_wdata = (widx == tgt[IW-1:0]) ? tdata : cb_rd;
            end
            default: ;
        endcase
        unique case (state_n)
            ST_PROG:                  tm_len = TW'(PROG_CYC);
            ST_COPY, ST_RESTORE:      tm_len = TW'(COPY_CYC);
            ST_CB_ERASE, ST_BLK_ERASE: tm_len = TW'(ERASE_CYC);
            default:                  tm_len = TW'(1);
        endcase
        tm_load = (state_n != state) || step;
        busy_o  = (state != ST_IDLE);
        irq_o   = (state == ST_FINISH);
        done_o  = done_q;
        rdata_o = rdata_q;
        ereq_o  = cb_full;
    end

    // request capture and word walk
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt     <= '0;
            tdata   <= '0;
            widx    <= '0;
            manual  <= 1'b0;
            done_q  <= 1'b0;
            rdata_q <= '0;
        end else begin
            if (state == ST_IDLE) begin
                widx <= '0;
                if (wr_req_i || rd_req_i || start_i) begin
                    tgt    <= addr_i;
                    tdata  <= wdata_i;
                    manual <= !wr_req_i && !rd_req_i;
                    done_q <= 1'b0;
                end
                if (!wr_req_i && rd_req_i) rdata_q <= ra_data;
            end else if (state == ST_FINISH) begin
                done_q <= 1'b1;
            end else if (state == ST_BLK_ERASE) begin
                widx <= '0;
            end else if (step) begin
                widx <= widx + 1'b1;
            end else if (state == ST_COPY && tm_exp) begin
                widx <= '0;
            end
        end
    end

    vslot_timer #(.TW(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tm_load), .len(tm_len), .expired(tm_exp)
    );

    vslot_main #(
        .DW(DATA_W), .NW(NW), .WPB(WORDS_PER_BLOCK), .SLOTS(SLOTS), .AW(ADDR_W), .BW(BW)
    ) u_main (
        .clk(clk), .rst_n(rst_n), .app_en(m_app), .rst_en(m_rst), .ers_en(m_ers),
        .w_idx(m_widx), .w_data(m_wdata), .ers_blk(tgt[ADDR_W-1:IW]),
        .ra_idx(addr_i), .ra_data(ra_data), .ra_full(ra_full),
        .rb_idx(rb_idx), .rb_data(rb_data)
    );

    vslot_cbuf #(
        .DW(DATA_W), .WPB(WORDS_PER_BLOCK), .FRAMES(CB_FRAMES), .IW(IW)
    ) u_cbuf (
        .clk(clk), .rst_n(rst_n), .wr_en(cb_wr), .commit(cb_commit), .erase(cb_ers),
        .idx(widx), .wr_data(rb_data), .rd_data(cb_rd), .full(cb_full)
    );
endmodule

// File: rtl/vslot_eeprom_chk.sv
module vslot_eeprom_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_req_i,
    input logic rd_req_i,
    input logic start_i,
    input logic busy_o,
    input logic done_o,
    input logic irq_o,
    input logic ereq_o
);
    a_r11_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    a_r11_done_after_irq: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> done_o);

    a_r11_done_low_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !done_o);

    a_r3_end_via_irq: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(irq_o));

    a_r8_ereq_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> $stable(ereq_o));

    a_r10_accept_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && (wr_req_i || rd_req_i || start_i)) |=> busy_o);
endmodule

bind vslot_eeprom vslot_eeprom_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_req_i(wr_req_i), .rd_req_i(rd_req_i),
    .start_i(start_i), .busy_o(busy_o), .done_o(done_o), .irq_o(irq_o),
    .ereq_o(ereq_o)
);

// File: tb/vslot_eeprom_tb.sv
`timescale 1ns/1ps
module vslot_eeprom_tb;
    localparam int DW = 16;
    localparam int AW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr = 1'b0, rd = 1'b0, start = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic busy, done, irq, ereq;

    int n_chk = 0, n_fail = 0, irq_cnt = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    vslot_eeprom #(
        .DATA_W(DW), .WORDS_PER_BLOCK(4), .BLOCKS(2), .SLOTS(7), .CB_FRAMES(2),
        .PROG_CYC(3), .COPY_CYC(2), .ERASE_CYC(20)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_req_i(wr), .rd_req_i(rd), .start_i(start),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .busy_o(busy),
        .done_o(done), .irq_o(irq), .ereq_o(ereq)
    );

    always @(negedge clk) if (irq) irq_cnt++;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_idle(output int lat);
        lat = 1;
        while (busy) begin @(negedge clk); lat++; end
    endtask

    // cls: 0 plain, 1 compaction, 2 compaction with buffer erase
    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input int cls, input string tag);
        int lat, i0;
        bit ok;
        i0 = irq_cnt;
        @(negedge clk); addr = a; wdata = d; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
        wait_idle(lat);
        if (cls == 0)      ok = (lat <= 8);
        else if (cls == 1) ok = (lat >= 20 && lat < 46);
        else               ok = (lat >= 46 && lat < 90);
        chk(ok, tag, lat, cls);
        chk(irq_cnt == i0 + 1 && done, "R11", irq_cnt - i0, 1);
    endtask

    task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
        int lat;
        @(negedge clk); addr = a; rd = 1'b1;
        @(negedge clk); rd = 1'b0;
        wait_idle(lat);
        chk(rdata == exp, tag, rdata, exp);
    endtask

    task automatic t_reset();
        chk(!busy && !done && !ereq, "R1", {busy, done, ereq}, 0);
        do_read(3'd0, 16'hFFFF, "R1");
        do_read(3'd7, 16'hFFFF, "R1");
    endtask

    task automatic t_fill_and_compact();
        do_write(3'd1, 16'h1111, 0, "R3");
        for (int k = 0; k < 3; k++) do_write(3'd5, 16'h5550 + DW'(k), 0, "R3");
        for (int k = 0; k < 7; k++) begin
            do_write(3'd0, 16'h0A00 + DW'(k), 0, "R4");
            do_read(3'd0, 16'h0A00 + DW'(k), "R2");
        end
        do_write(3'd0, 16'h0B00, 1, "R4");
        do_read(3'd0, 16'h0B00, "R5");
        do_read(3'd1, 16'h1111, "R5");
        do_read(3'd2, 16'hFFFF, "R5");
        chk(!ereq, "R8", ereq, 0);
    endtask

    task automatic t_after_compact();
        for (int k = 0; k < 6; k++) do_write(3'd1, 16'h2100 + DW'(k), 0, "R6");
        for (int k = 0; k < 6; k++) do_write(3'd0, 16'h0C00 + DW'(k), 0, "R6");
        do_write(3'd0, 16'h0D00, 1, "R6");
        do_read(3'd1, 16'h2105, "R5");
        chk(ereq, "R8", ereq, 1);
        do_read(3'd5, 16'h5552, "R7");
    endtask

    task automatic t_busy_ignored();
        int lat;
        @(negedge clk); addr = 3'd2; wdata = 16'hAAAA; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
        @(negedge clk); wdata = 16'hBBBB; wr = 1'b1; rd = 1'b1; start = 1'b1;
        @(negedge clk); wr = 1'b0; rd = 1'b0; start = 1'b0;
        wait_idle(lat);
        do_read(3'd2, 16'hAAAA, "R10");
        chk(ereq, "R10", ereq, 1);
    endtask

    task automatic t_long_and_manual();
        int lat, i0;
        for (int k = 0; k < 4; k++) do_write(3'd5, 16'h5600 + DW'(k), 0, "R7");
        do_write(3'd5, 16'h5700, 2, "R8");
        chk(!ereq, "R8", ereq, 0);
        do_read(3'd5, 16'h5700, "R5");
        do_read(3'd0, 16'h0D00, "R7");
        for (int k = 0; k < 6; k++) do_write(3'd5, 16'h5800 + DW'(k), 0, "R6");
        do_write(3'd5, 16'h5900, 1, "R4");
        chk(ereq, "R8", ereq, 1);
        i0 = irq_cnt;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(busy, "R9", busy, 1);
        wait_idle(lat);
        chk(irq_cnt == i0 + 1 && done, "R9", irq_cnt - i0, 1);
        chk(!ereq, "R9", ereq, 0);
        for (int k = 0; k < 6; k++) do_write(3'd5, 16'h5A00 + DW'(k), 0, "R6");
        do_write(3'd5, 16'h5B00, 1, "R9");
        do_read(3'd5, 16'h5B00, "R2");
        do_read(3'd4, 16'hFFFF, "R5");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fill_and_compact();
        t_after_compact();
        t_busy_ignored();
        t_long_and_manual();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #800000;
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule